// File: doc/BRIEF.md
# FIR Stream Output Window Controller

This block sits between a sample source and a streaming FIR core and decides which convolution samples of each stream reach the output. A stream is started with a run-time length N and tap count L. The block passes N real samples to the core. It then feeds the core as many zero samples as the chosen window still needs. Of the core's results, it forwards only those inside the window that the style setting selects. The core itself, with its multiply and add work, lives outside the block. The block sees only the core's input and output strobes, so the core may have any pipeline latency.

Four window styles exist. The first style keeps the leading N results. The centred style keeps N results from the middle of the convolution, so a row or column comes out as long as it went in. The full style keeps all N+L−1 results. The streaming style never ends a stream. When a non-streaming stream has emitted its last sample, the block marks that sample, clears the core's register chain for one cycle and goes idle. A reconfiguration-done pulse aborts whatever is in flight: the core is cleared, a flush pulse goes to the downstream FIFO, and nothing more is emitted.

Top module: `fir_window_ctl`

## Requirements
- R1: After reset, out_vld, out_last, in_rdy, core_din_vld, core_clr and fifo_flush are all low.
- R2: With cfg_style = 0, a stream emits exactly convolution samples 0 … N−1, in order.
- R3: With cfg_style = 1, a stream emits exactly convolution samples S … S+N−1, in order, where S = floor((L−1)/2).
- R4: With cfg_style = 2, a stream emits all N+L−1 convolution samples, in order.
- R5: With cfg_style = 3, in_rdy stays high, every accepted sample yields one emitted convolution sample, and out_last is never raised.
- R6: Exactly N real samples are accepted, after which in_rdy falls. The block then drives core_din_vld with core_din = 0 for exactly (number of samples the window needs) − N cycles: 0 for style 0, S for style 1 and L−1 for style 2.
- R7: out_last is high together with out_vld on the final emitted sample of each non-streaming stream, and on no other sample.
- R8: In the cycle after out_last, core_clr is high for one cycle. A following stream therefore starts with no history from the previous one.
- R9: One cycle after recfg_done, core_clr and fifo_flush are high and out_vld is low. The block then returns to idle with in_rdy low.
- R10: start and any change of cfg_len, cfg_taps or cfg_style while a stream is active have no effect on that stream's emitted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a stream (taken only when idle) |
| cfg_len | input | LEN_W | Stream length N |
| cfg_taps | input | TAP_W | Tap count L (0 treated as 1) |
| cfg_style | input | 2 | Window style: 0 leading, 1 centred, 2 full, 3 streaming |
| recfg_done | input | 1 | Reconfiguration finished; abort and flush |
| in_data | input | DATA_W | Input sample |
| in_vld | input | 1 | Input sample valid |
| in_rdy | output | 1 | Block accepts an input sample |
| core_din | output | DATA_W | Sample to the FIR core |
| core_din_vld | output | 1 | Core input strobe |
| core_clr | output | 1 | Clear the core's register chain |
| core_dout | input | CORE_W | Core result |
| core_dout_vld | input | 1 | Core result strobe |
| out_data | output | CORE_W | Emitted sample |
| out_vld | output | 1 | Emitted sample valid |
| out_last | output | 1 | Final sample of the stream |
| fifo_flush | output | 1 | Reset pulse for the output FIFO |

## Verification
An emitted sample appears on out_data one cycle after the core strobes its result. With the bench's one-register core model, that is two cycles after the sample entered the core. The bench therefore records outputs at every falling edge and compares the recorded sequence with a convolution it computes itself, rather than looking for a sample at a fixed cycle. The core_clr pulse comes one cycle after out_last. in_rdy falls at the first falling edge after the Nth accepting edge. core_clr, fifo_flush and the silenced out_vld are checked at the first falling edge after the edge that samples recfg_done.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        STY_LEAD   = 2'd0,
        STY_CENTER = 2'd1,
        STY_FULL   = 2'd2,
        STY_STREAM = 2'd3
    } style_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_CLEAR = 2'd2
    } phase_e;

endpackage

// File: rtl/fwc_window.sv
// Derives the emission window of one stream from its latched configuration.
module fwc_window
    import fwc_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TAP_W = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic [LEN_W-1:0] len,
    input  logic [TAP_W-1:0] taps,
    input  style_e           style,
    output logic [CNT_W-1:0] skip,
    output logic [CNT_W-1:0] total,
    output logic             endless
);
    logic [CNT_W-1:0] tail;
    logic [CNT_W-1:0] half;

    always_comb begin
        // L-1 zero samples flush the complete tail of the convolution
        tail    = (taps == '0) ? '0 : CNT_W'(taps) - CNT_W'(1);
        half    = tail >> 1;
        endless = (style == STY_STREAM);
        skip    = '0;
        total   = CNT_W'(len);
        case (style)
            STY_CENTER: begin
                skip  = half;
                total = CNT_W'(len) + half;
            end
            STY_FULL:   total = CNT_W'(len) + tail;
            default:    total = CNT_W'(len);
        endcase
    end

endmodule

// File: rtl/fwc_feeder.sv
// Hands N real samples to the core, then injects zero samples up to the window end.
module fwc_feeder #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 12,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [LEN_W-1:0]  len,
    input  logic [CNT_W-1:0]  total,
    input  logic              endless,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    output logic              in_rdy,
    output logic [DATA_W-1:0] core_din,
    output logic              core_din_vld
);
    typedef struct packed {
        logic [CNT_W-1:0] fed;
    } feed_t;

    feed_t st_d, st_q;
    logic  real_phase;
    logic  zero_phase;

    always_comb begin
        st_d       = st_q;
        real_phase = st_q.fed < CNT_W'(len);
        zero_phase = !real_phase && (st_q.fed < total);
        in_rdy     = run && (endless || real_phase);
        core_din   = '0;
        core_din_vld = 1'b0;
        if (run) begin
            if (endless || real_phase) begin
                core_din     = in_data;
                core_din_vld = in_vld;
            end else if (zero_phase) begin
                core_din_vld = 1'b1;
            end
        end
        if (clear) begin
            st_d.fed = '0;
        end else if (core_din_vld && !endless) begin
            st_d.fed = st_q.fed + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fwc_gate.sv
// Counts core results and forwards only those inside the window, marking the last.
module fwc_gate #(
    parameter int CORE_W = 16,
    parameter int LEN_W  = 12,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [CNT_W-1:0]  skip,
    input  logic [CNT_W-1:0]  total,
    input  logic              endless,
    input  logic [CORE_W-1:0] core_dout,
    input  logic              core_dout_vld,
    output logic [CORE_W-1:0] out_data,
    output logic              out_vld,
    output logic              out_last
);
    typedef struct packed {
        logic [CNT_W-1:0]  idx;
        logic [CORE_W-1:0] data;
        logic              vld;
        logic              last;
    } gate_t;

    gate_t st_d, st_q;
    logic  in_win;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.last = 1'b0;
        in_win    = (st_q.idx >= skip) && (st_q.idx < total);
        if (clear) begin
            st_d = '0;
        end else if (run && core_dout_vld) begin
            if (endless) begin
                st_d.vld  = 1'b1;
                st_d.data = core_dout;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
                if (in_win) begin
                    st_d.vld  = 1'b1;
                    st_d.data = core_dout;
                    st_d.last = (st_q.idx == total - CNT_W'(1));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.data;
    assign out_vld  = st_q.vld;
    assign out_last = st_q.last;

endmodule

// File: rtl/fir_window_ctl.sv
module fir_window_ctl
    import fwc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CORE_W = 16,
    parameter int LEN_W  = 12,
    parameter int TAP_W  = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [TAP_W-1:0]  cfg_taps,
    input  logic [1:0]        cfg_style,
    input  logic              recfg_done,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    output logic              in_rdy,
    output logic [DATA_W-1:0] core_din,
    output logic              core_din_vld,
    output logic              core_clr,
    input  logic [CORE_W-1:0] core_dout,
    input  logic              core_dout_vld,
    output logic [CORE_W-1:0] out_data,
    output logic              out_vld,
    output logic              out_last,
    output logic              fifo_flush
);
    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] len;
        logic [TAP_W-1:0] taps;
        style_e           style;
        logic             flush;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic             take;
    logic             sub_clear;
    logic             run;
    logic [CNT_W-1:0] skip;
    logic [CNT_W-1:0] total;
    logic             endless;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        take       = start && (st_q.phase == PH_IDLE) && !recfg_done;
        sub_clear  = take || recfg_done;
        if (recfg_done) begin
            st_d.phase = PH_CLEAR;
            st_d.flush = 1'b1;
        end else begin
            case (st_q.phase)
                PH_IDLE: if (take) begin
                    st_d.phase = PH_RUN;
                    st_d.len   = cfg_len;
                    st_d.taps  = cfg_taps;
                    st_d.style = style_e'(cfg_style);
                end
                PH_RUN:   if (out_last) st_d.phase = PH_CLEAR;
                default:  st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run        = (st_q.phase == PH_RUN);
    assign core_clr   = (st_q.phase == PH_CLEAR);
    assign fifo_flush = st_q.flush;

    fwc_window #(.LEN_W(LEN_W), .TAP_W(TAP_W)) u_window (
        .len     (st_q.len),
        .taps    (st_q.taps),
        .style   (st_q.style),
        .skip    (skip),
        .total   (total),
        .endless (endless)
    );

    fwc_feeder #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_feeder (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (sub_clear),
        .run          (run),
        .len          (st_q.len),
        .total        (total),
        .endless      (endless),
        .in_data      (in_data),
        .in_vld       (in_vld),
        .in_rdy       (in_rdy),
        .core_din     (core_din),
        .core_din_vld (core_din_vld)
    );

    fwc_gate #(.CORE_W(CORE_W), .LEN_W(LEN_W)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (sub_clear),
        .run           (run),
        .skip          (skip),
        .total         (total),
        .endless       (endless),
        .core_dout     (core_dout),
        .core_dout_vld (core_dout_vld),
        .out_data      (out_data),
        .out_vld       (out_vld),
        .out_last      (out_last)
    );

endmodule

// File: rtl/fwc_chk.sv
module fwc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              recfg_done,
    input logic              in_vld,
    input logic              in_rdy,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] core_din,
    input logic              core_din_vld,
    input logic              core_clr,
    input logic              out_vld,
    input logic              out_last,
    input logic              fifo_flush
);
    // R7
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);

    // R8
    clear_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> core_clr);

    // R8
    no_accept_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clr |-> !in_rdy);

    // R6
    accepted_to_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_vld) |-> (core_din_vld && core_din == in_data));

    // R6
    injected_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_din_vld && !in_rdy) |-> (core_din == '0));

    // R9
    recfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recfg_done |=> (fifo_flush && core_clr && !out_vld));

endmodule

bind fir_window_ctl fwc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .recfg_done   (recfg_done),
    .in_vld       (in_vld),
    .in_rdy       (in_rdy),
    .in_data      (in_data),
    .core_din     (core_din),
    .core_din_vld (core_din_vld),
    .core_clr     (core_clr),
    .out_vld      (out_vld),
    .out_last     (out_last),
    .fifo_flush   (fifo_flush)
);

// File: tb/fir_window_ctl_test.sv
module fir_window_ctl_test;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int CORE_W = 16;
    localparam int LEN_W  = 12;
    localparam int TAP_W  = 6;
    localparam int NVEC   = 8;
    // columns: N, L, style
    localparam int VEC [NVEC][3] = '{
        '{5, 3, 0}, '{5, 3, 1}, '{5, 3, 2}, '{6, 4, 1},
        '{4, 1, 2}, '{1, 5, 2}, '{7, 5, 1}, '{3, 6, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [TAP_W-1:0]  cfg_taps = '0;
    logic [1:0]        cfg_style = '0;
    logic              recfg_done = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_vld = 1'b0;
    logic              in_rdy;
    logic [DATA_W-1:0] core_din;
    logic              core_din_vld;
    logic              core_clr;
    logic [CORE_W-1:0] core_dout;
    logic              core_dout_vld;
    logic [CORE_W-1:0] out_data;
    logic              out_vld;
    logic              out_last;
    logic              fifo_flush;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    fir_window_ctl #(.DATA_W(DATA_W), .CORE_W(CORE_W), .LEN_W(LEN_W), .TAP_W(TAP_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len), .cfg_taps(cfg_taps),
        .cfg_style(cfg_style), .recfg_done(recfg_done), .in_data(in_data), .in_vld(in_vld),
        .in_rdy(in_rdy), .core_din(core_din), .core_din_vld(core_din_vld), .core_clr(core_clr),
        .core_dout(core_dout), .core_dout_vld(core_dout_vld), .out_data(out_data),
        .out_vld(out_vld), .out_last(out_last), .fifo_flush(fifo_flush)
    );

    // Core model: all-ones L-tap FIR, one register of latency.
    logic [DATA_W-1:0] hist [0:15];
    int model_taps = 1;
    always @(posedge clk) begin
        int sum;
        if (!rst_n || core_clr) begin
            for (int i = 0; i < 16; i++) hist[i] <= '0;
            core_dout     <= '0;
            core_dout_vld <= 1'b0;
        end else begin
            core_dout_vld <= core_din_vld;
            if (core_din_vld) begin
                sum = int'(core_din);
                for (int i = 0; i < model_taps - 1; i++) sum += int'(hist[i]);
                for (int i = 15; i > 0; i--) hist[i] <= hist[i-1];
                hist[0]   <= core_din;
                core_dout <= CORE_W'(sum);
            end
        end
    end

    // Output and zero-injection monitor
    logic [CORE_W-1:0] got_d [0:63];
    logic              got_l [0:63];
    int mcount = 0;
    int zcount = 0;
    always @(negedge clk) begin
        cycles++;
        if (out_vld && mcount < 64) begin
            got_d[mcount] = out_data;
            got_l[mcount] = out_last;
            mcount++;
        end
        if (core_din_vld && !in_rdy) zcount++;
    end

    always @(negedge clk) begin
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int xval(input int base, input int i);
        return (base + i * 11 + 5) & 255;
    endfunction

    function automatic int conv(input int base, input int n, input int l, input int k);
        int s = 0;
        for (int j = 0; j < l; j++)
            if (k - j >= 0 && k - j < n) s += xval(base, k - j);
        return s;
    endfunction

    // disturb = 1 pulses start with another configuration mid-stream (R10)
    task automatic run_stream(input int n, input int l, input int sty, input int base,
                              input bit disturb);
        int skip, cnt, accepted, waitc, lm1;
        string req;
        lm1  = (l > 0) ? l - 1 : 0;
        skip = (sty == 1) ? lm1 / 2 : 0;
        cnt  = (sty == 2) ? n + lm1 : n;
        req  = (sty == 0) ? "R2" : (sty == 1) ? "R3" : (sty == 2) ? "R4" : "R5";
        model_taps = (l > 0) ? l : 1;
        @(negedge clk);
        mcount = 0;
        zcount = 0;
        cfg_len = LEN_W'(n); cfg_taps = TAP_W'(l); cfg_style = 2'(sty);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        accepted = 0;
        waitc = 0;
        while (accepted < n && waitc < 1000) begin
            in_data = DATA_W'(xval(base, accepted));
            in_vld  = 1'b1;
            if (disturb && accepted == 1) begin
                start = 1'b1; cfg_len = LEN_W'(2); cfg_taps = TAP_W'(5); cfg_style = 2'd0;
            end else begin
                start = 1'b0;
            end
            if (in_rdy) accepted++;
            @(negedge clk);
            waitc++;
        end
        in_vld = 1'b0;
        start  = 1'b0;
        if (sty == 3) begin
            repeat (4) @(negedge clk);
            chk(in_rdy == 1'b1, "R5 in_rdy stays high", int'(in_rdy), 1);
        end else begin
            chk(in_rdy == 1'b0, "R6 in_rdy after N", int'(in_rdy), 0);
            waitc = 0;
            while (!(mcount > 0 && got_l[mcount-1]) && waitc < 200) begin
                @(negedge clk);
                waitc++;
            end
            @(negedge clk);
            chk(zcount == skip + cnt - n, "R6 zero count", zcount, skip + cnt - n);
        end
        chk(mcount == cnt, {req, " sample count"}, mcount, cnt);
        for (int k = 0; k < cnt && k < mcount; k++) begin
            chk(int'(got_d[k]) == conv(base, n, l, skip + k), {req, " sample value"},
                int'(got_d[k]), conv(base, n, l, skip + k));
            chk(got_l[k] == (sty != 3 && k == cnt - 1), "R7 out_last placement",
                int'(got_l[k]), int'(sty != 3 && k == cnt - 1));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_vld && !out_last && !in_rdy, "R1 outputs idle", int'(out_vld), 0);
        chk(!core_din_vld && !core_clr && !fifo_flush, "R1 core side idle",
            int'(core_din_vld), 0);

        // Table walk; vector 7 (style 0, no tail zeros) follows vector 6 and
        // only matches if the core was cleared between streams (R8).
        for (int v = 0; v < NVEC; v++)
            run_stream(VEC[v][0], VEC[v][1], VEC[v][2], v * 37, 1'b0);

        // R10: second start and new configuration mid-stream are ignored
        run_stream(4, 2, 2, 91, 1'b1);

        // R5: streaming style, then R9 abort by reconfiguration
        run_stream(8, 3, 3, 55, 1'b0);
        @(negedge clk);
        recfg_done = 1'b1;
        @(negedge clk);
        recfg_done = 1'b0;
        chk(fifo_flush == 1'b1, "R9 fifo_flush", int'(fifo_flush), 1);
        chk(core_clr == 1'b1, "R9 core_clr", int'(core_clr), 1);
        chk(out_vld == 1'b0, "R9 out_vld silent", int'(out_vld), 0);
        @(negedge clk);
        chk(in_rdy == 1'b0 && fifo_flush == 1'b0, "R9 idle after abort", int'(in_rdy), 0);

        // R8/R9: fresh stream after abort starts with a clean core
        run_stream(3, 2, 0, 13, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule